// File: doc/BRIEF.md
# Four-Line I/O Port Controller with Stored Power-On Defaults

This block controls four bidirectional pins. For each line it keeps a direction, an output value, an output type and a read-inversion setting. The pad ring sees a per-line output enable and output data signal, and the block returns the sampled pin levels. Software reads and writes these settings through a byte-wide register port: an address, a write enable, write data, and read data that follows the address combinationally. Open-drain lines are emulated: when a high is written, the driver is released instead of driven high, and an external pull-up supplies the level.

After master reset every pin is tri-stated for one cycle. On the first clock edge after reset is released, the live settings are loaded from two stored default bytes. A third stored byte acts as a key. When it holds AAh at load time, a read-only status register is enabled that mirrors the raw levels of lines 0 and 1. Pin access works in one of two layouts, selected by a control bit. In the single-register layout, one byte presents all four lines. In the per-line layout, each line has its own register.

Top module: `nvgpio_ctrl`

## Requirements
- R1: While `rstN` is low, and in the cycle after its release up to the first rising clock edge, `pinOe` is 0000b.
- R2: On the first rising edge after reset release, the settings are loaded as follows:
  - direction from `defDirVal[7:4]` and output values from `defDirVal[3:0]`;
  - output type from `defTypeInv[7:4]` and inversion from `defTypeInv[3:0]`;
  - the access-mode bit is cleared, which selects the per-line layout.
- R3: A direction bit of 1 makes a line an input, so `pinOe[n]` is 0. A direction bit of 0 makes it an output.
- R4: An output line of push-pull type (type bit 0) drives `pinOe[n]`=1 with `pinOut[n]` equal to its output value. An open-drain line (type bit 1) drives low when its value is 0 and releases (`pinOe[n]`=0) when its value is 1. `pinOut` is meaningful only where `pinOe` is 1.
- R5: The input value of line n is the pin level after a two-flop synchronizer, XORed with inversion bit n. It appears in reads on the second rising edge after the pin changes.
- R6: With control bit 7 = 1 (single-register layout):
  - address 4 reads {input values[3:0], output values[3:0]};
  - a write to address 4 loads the output values from bits 3:0;
  - addresses 5 to 7 read 00h and ignore writes.
- R7: With control bit 7 = 0 (per-line layout), address 4+n serves line n:
  - bit 4 is the input value and bit 0 is the output value;
  - all other bits read 1;
  - a write changes only the output value, taken from bit 0.
- R8: The mirror flag is set at load when `defModeKey` equals AAh, and reads back at control bit 4. Address 2 then reads {00000b, level of line 1, level of line 0, 0b}, using the synchronized pin levels without inversion. With the flag clear, address 2 reads 00h.
- R9: A set mirror flag does not change the direction of lines 0 and 1.
- R10: The control register is at address 0:
  - bit 7 is the access mode and bits 3:0 are the directions;
  - bit 4 is the read-only mirror flag;
  - bits 6:5 read 0.

  The configuration register is at address 1: type in bits 7:4, inversion in bits 3:0. Address 3 reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous master reset, active low |
| defDirVal | input | 8 | Stored default: directions [7:4], output values [3:0] |
| defTypeInv | input | 8 | Stored default: output types [7:4], inversion [3:0] |
| defModeKey | input | 8 | Stored key byte; AAh enables the status mirror |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for `regAddr` |
| pinIn | input | 4 | Pin levels from the pads |
| pinOe | output | 4 | Per-line driver enable |
| pinOut | output | 4 | Per-line driven value |

## Verification
A wrong direction or type bit shows at `pinOe` in the cycle after the write or load that set it. The pull-up pad model then turns it into a wrong input value two cycles later. A corrupted inversion bit or synchronizer stage is visible only in reads, two edges after the pin changes. A layout-decode fault shows at once as a wrong read pattern, or as an output value that changes after a write that should have been ignored.

// File: rtl/nvgpio_pkg.sv
package nvgpio_pkg;
  localparam int LINES  = 4;
  localparam int LIDX_W = $clog2(LINES);
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_CFG  = 1;
  localparam int ADDR_STAT = 2;

  typedef enum logic [2:0] {
    RD_ZERO, RD_CTRL, RD_CFG, RD_STAT, RD_SINGLE, RD_LINE
  } rdSel_e;

  typedef struct packed {
    logic              wrCtrl;
    logic              wrCfg;
    logic              wrSingle;
    logic              wrLine;
    logic [LIDX_W-1:0] lineIdx;
    rdSel_e            rdSel;
  } strobe_t;
endpackage

// File: rtl/nvgpio_regctl.sv
module nvgpio_regctl
  import nvgpio_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int PIN_BASE = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              accSingle,
  output strobe_t           strb
);
  logic [ADDR_W-1:0] offs;
  logic              inPinWin;

  assign offs     = regAddr - ADDR_W'(PIN_BASE);
  assign inPinWin = (int'(regAddr) >= PIN_BASE) && (int'(offs) < LINES);

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_ZERO;
    strb.lineIdx = offs[LIDX_W-1:0];
    if (int'(regAddr) == ADDR_CTRL) begin
      strb.rdSel  = RD_CTRL;
      strb.wrCtrl = regWrEn;
    end else if (int'(regAddr) == ADDR_CFG) begin
      strb.rdSel = RD_CFG;
      strb.wrCfg = regWrEn;
    end else if (int'(regAddr) == ADDR_STAT) begin
      strb.rdSel = RD_STAT;
    end else if (inPinWin) begin
      if (accSingle) begin
        if (offs == '0) begin
          strb.rdSel    = RD_SINGLE;
          strb.wrSingle = regWrEn;
        end
      end else begin
        strb.rdSel  = RD_LINE;
        strb.wrLine = regWrEn;
      end
    end
  end
endmodule

// File: rtl/nvgpio_datapath.sv
module nvgpio_datapath
  import nvgpio_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MIRROR_KEY  = 8'hAA
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [7:0]       regWrData,
  input  logic [7:0]       defDirVal,
  input  logic [7:0]       defTypeInv,
  input  logic [7:0]       defModeKey,
  input  logic [LINES-1:0] pinIn,
  output logic [LINES-1:0] pinOe,
  output logic [LINES-1:0] pinOut,
  output logic [7:0]       regRdData,
  output logic             accSingle
);
  logic                                  loading;
  logic                                  mirrorOn;
  logic [LINES-1:0]                      dirQ, ovQ, otQ, invQ;
  logic [SYNC_STAGES-1:0][LINES-1:0]     syncQ;
  logic [LINES-1:0]                      pinLevel, inVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
    end
  end

  assign pinLevel = syncQ[SYNC_STAGES-1];
  assign inVal    = pinLevel ^ invQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loading   <= 1'b1;
      dirQ      <= '1;
      ovQ       <= '0;
      otQ       <= '0;
      invQ      <= '0;
      accSingle <= 1'b0;
      mirrorOn  <= 1'b0;
    end else if (loading) begin
      loading   <= 1'b0;
      dirQ      <= defDirVal[7:4];
      ovQ       <= defDirVal[3:0];
      otQ       <= defTypeInv[7:4];
      invQ      <= defTypeInv[3:0];
      accSingle <= 1'b0;
      mirrorOn  <= (defModeKey == MIRROR_KEY);
    end else begin
      if (strb.wrCtrl) begin
        accSingle <= regWrData[7];
        dirQ      <= regWrData[3:0];
      end
      if (strb.wrCfg) begin
        otQ  <= regWrData[7:4];
        invQ <= regWrData[3:0];
      end
      if (strb.wrSingle) ovQ <= regWrData[3:0];
      if (strb.wrLine)   ovQ[strb.lineIdx] <= regWrData[0];
    end
  end

  for (genvar n = 0; n < LINES; n++) begin : g_pad
    assign pinOe[n]  = !loading && !dirQ[n] && !(otQ[n] && ovQ[n]);
    assign pinOut[n] = ovQ[n] && !otQ[n];
  end

  always_comb begin
    case (strb.rdSel)
      RD_CTRL:   regRdData = {accSingle, 2'b00, mirrorOn, dirQ};
      RD_CFG:    regRdData = {otQ, invQ};
      RD_STAT:   regRdData = mirrorOn ? {5'b0, pinLevel[1], pinLevel[0], 1'b0} : 8'h00;
      RD_SINGLE: regRdData = {inVal, ovQ};
      RD_LINE:   regRdData = {3'b111, inVal[strb.lineIdx], 3'b111, ovQ[strb.lineIdx]};
      default:   regRdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/nvgpio_ctrl.sv
module nvgpio_ctrl
  import nvgpio_pkg::*;
#(
  parameter int         ADDR_W      = 3,
  parameter int         PIN_BASE    = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] MIRROR_KEY  = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        defDirVal,
  input  logic [7:0]        defTypeInv,
  input  logic [7:0]        defModeKey,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [3:0]        pinIn,
  output logic [3:0]        pinOe,
  output logic [3:0]        pinOut
);
  strobe_t strb;
  logic    accSingle;

  nvgpio_regctl #(.ADDR_W(ADDR_W), .PIN_BASE(PIN_BASE)) i_regctl (
    .regAddr(regAddr), .regWrEn(regWrEn), .accSingle(accSingle), .strb(strb)
  );

  nvgpio_datapath #(.SYNC_STAGES(SYNC_STAGES), .MIRROR_KEY(MIRROR_KEY)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .defDirVal(defDirVal), .defTypeInv(defTypeInv), .defModeKey(defModeKey),
    .pinIn(pinIn), .pinOe(pinOe), .pinOut(pinOut),
    .regRdData(regRdData), .accSingle(accSingle)
  );
endmodule

// File: rtl/nvgpio_chk.sv
module nvgpio_chk #(
  parameter int ADDR_W   = 3,
  parameter int PIN_BASE = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        defDirVal,
  input logic [7:0]        defTypeInv,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [3:0]        wrDir,
  input logic [7:0]        regRdData,
  input logic [3:0]        pinOe
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1: no line driven before the load edge
  p_tristate_before_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd0) |-> (pinOe == 4'b0000));

  // R2: enables right after load follow the stored defaults
  p_defaults_loaded_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd1) |-> (pinOe == (~$past(defDirVal[7:4]) &
                                      ~($past(defTypeInv[7:4]) & $past(defDirVal[3:0])))));

  // R3: lines written as inputs are not driven
  p_input_released_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && int'(regAddr) == 0 && sinceRst != 2'd0) |=> ((pinOe & $past(wrDir)) == 4'b0000));

  // R7: upper pin-access registers read either 00h or the fixed-ones pattern
  p_pin_reg_shape_r7: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr) > PIN_BASE && int'(regAddr) < PIN_BASE + 4) |->
      (regRdData == 8'h00 || (regRdData & 8'hEE) == 8'hEE));

  // R8: status register carries only bits 2:1
  p_status_bits_r8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr) == 2) |-> ((regRdData & 8'hF9) == 8'h00));
endmodule

bind nvgpio_ctrl nvgpio_chk #(.ADDR_W(ADDR_W), .PIN_BASE(PIN_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .defDirVal(defDirVal), .defTypeInv(defTypeInv),
  .regAddr(regAddr), .regWrEn(regWrEn), .wrDir(regWrData[3:0]),
  .regRdData(regRdData), .pinOe(pinOe)
);

// File: tb/test_nvgpio_ctrl.sv
module test_nvgpio_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] defDirVal = 8'hF0, defTypeInv = 8'hF0, defModeKey = 8'h00;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [3:0] pinIn, pinOe, pinOut;
  logic [3:0] extEn = '0, extVal = '0;
  int nChecks = 0, nErrors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // pad model: driver wins, else external source, else pull-up
  always_comb
    for (int n = 0; n < 4; n++)
      pinIn[n] = pinOe[n] ? pinOut[n] : (extEn[n] ? extVal[n] : 1'b1);

  nvgpio_ctrl i_nvgpio_ctrl (
    .clk(clk), .rstN(rstN), .defDirVal(defDirVal), .defTypeInv(defTypeInv),
    .defModeKey(defModeKey), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOe(pinOe), .pinOut(pinOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitN(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] expOe(input logic [3:0] dir, ov, ot);
    return ~dir & ~(ot & ov);
  endfunction

  task automatic doReset(input logic [7:0] a, b, key);
    @(negedge clk);
    rstN = 1'b0; defDirVal = a; defTypeInv = b; defModeKey = key;
    @(negedge clk);
    chk("R1 in reset", {4'h0, pinOe}, 8'h00);
    rstN = 1'b1;
    #1;
    chk("R1 before load", {4'h0, pinOe}, 8'h00);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d, b, key;
    logic [3:0] oe, inv, lvl;
    // R2, R8 load sweep over every direction/value default byte
    for (int a = 0; a < 256; a++) begin
      b   = {a[3:0], a[7:4]} ^ 8'h3C;
      key = (a[2:0] == 3'd5) ? 8'hAA : 8'(a);
      doReset(8'(a), b, key);
      oe = expOe(a[7:4], a[3:0], b[7:4]);
      chk("R2 oe after load", {4'h0, pinOe}, {4'h0, oe});
      chk("R4 out after load", {4'h0, pinOut & oe}, {4'h0, a[3:0] & oe});
      rd(3'd0, d);
      chk("R2 R8 control after load", d, {3'b000, key == 8'hAA, a[7:4]});
      rd(3'd1, d);
      chk("R2 config after load", d, b);
    end

    // R3 R4 R5 R6: all outputs, sweep type and value, single layout
    doReset(8'h00, 8'h00, 8'h00);
    wr(3'd0, 8'h80);
    for (int ot = 0; ot < 16; ot++)
      for (int ov = 0; ov < 16; ov++) begin
        inv = 4'(ot) ^ 4'hA;
        wr(3'd1, {4'(ot), inv});
        wr(3'd4, {4'h0, 4'(ov)});
        waitN(2);
        oe = expOe(4'h0, 4'(ov), 4'(ot));
        chk("R4 oe", {4'h0, pinOe}, {4'h0, oe});
        chk("R4 driven level", {4'h0, pinOut & oe}, {4'h0, 4'(ov) & oe});
        rd(3'd4, d);
        chk("R6 R5 single read", d, {4'(ov) ^ inv, 4'(ov)});
      end

    // R6: writes to 5..7 ignored, they read 00h
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h05);
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFA); wr(3'd7, 8'h0F);
    waitN(2);
    rd(3'd4, d);
    chk("R6 ignored writes keep values", d, 8'h55);
    chk("R6 pins unchanged", {4'h0, pinOut}, 8'h05);
    for (int r = 5; r < 8; r++) begin
      rd(3'(r), d);
      chk("R6 unused read", d, 8'h00);
    end

    // R5 latency: pin change visible on second edge
    wr(3'd0, 8'h8F);
    extEn = 4'hF; extVal = 4'h0;
    waitN(3);
    extVal = 4'h9;
    @(negedge clk);
    rd(3'd4, d);
    chk("R5 one edge old", d, 8'h05);
    @(negedge clk);
    rd(3'd4, d);
    chk("R5 two edges new", d, 8'h95);

    // R3 R5 R7: inputs, per-line layout, sweep ext level and inversion
    wr(3'd0, 8'h0F);
    for (int ev = 0; ev < 16; ev++)
      for (int iv = 0; iv < 16; iv++) begin
        extVal = 4'(ev);
        wr(3'd1, {4'h0, 4'(iv)});
        waitN(2);
        chk("R3 inputs not driven", {4'h0, pinOe}, 8'h00);
        lvl = 4'(ev) ^ 4'(iv);
        for (int n = 0; n < 4; n++) begin
          rd(3'(4 + n), d);
          chk("R7 line read", d, {3'b111, lvl[n], 3'b111, 4'h5 >> n & 4'h1 ? 1'b1 : 1'b0});
        end
      end

    // R7: per-line writes touch only bit 0 of the addressed line
    extEn = 4'h0;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    for (int n = 0; n < 4; n++) begin
      wr(3'(4 + n), 8'hFE);
      waitN(2);
      rd(3'(4 + n), d);
      chk("R7 cleared", d, 8'hEE);
      wr(3'(4 + n), 8'h01);
      waitN(2);
      rd(3'(4 + n), d);
      chk("R7 set", d, 8'hFF);
    end
    chk("R3 R7 outputs driven", {4'h0, pinOe}, 8'h0F);
    chk("R7 all high", {4'h0, pinOut}, 8'h0F);
    wr(3'd6, 8'hF0);
    @(negedge clk);
    chk("R7 one line only", {4'h0, pinOut}, 8'h0B);

    // R8 R9: mirror on, lines 0/1 stay outputs
    doReset(8'h00, 8'h00, 8'hAA);
    chk("R9 lines stay outputs", {4'h0, pinOe}, 8'h0F);
    rd(3'd0, d);
    chk("R8 flag set", d, 8'h10);
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h0F);
    for (int v = 0; v < 4; v++) begin
      wr(3'd4, {4'h0, 4'(v)});
      waitN(2);
      rd(3'd2, d);
      chk("R8 status mirror raw", d, {5'b0, v[1], v[0], 1'b0});
    end
    doReset(8'h00, 8'h00, 8'hAB);
    wr(3'd0, 8'h80);
    wr(3'd4, 8'h03);
    waitN(2);
    rd(3'd2, d);
    chk("R8 status off", d, 8'h00);

    // R10: fixed bits and reserved address
    wr(3'd0, 8'h7F);
    rd(3'd0, d);
    chk("R10 control fixed bits", d, 8'h0F);
    rd(3'd3, d);
    chk("R10 reserved", d, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end
endmodule